// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Controller

This block runs one bus machine cycle for an 8-bit processor core with a 16-bit address, where the low address byte and the data byte share one set of eight bus lines. The core presents a request that names the cycle kind, the address and, for writes, the data byte. The controller then steps through the T-states of that cycle. It drives the high address byte, the shared lines with an output enable, the address latch strobe, active-low read and write strobes, and three status lines that tell external logic what kind of cycle is running.

The sequencer runs on a clock at twice the T-state rate, so each T-state is two clocks long and every strobe can change at a half-state point. An opcode fetch lasts four T-states; the fourth is a decode slot with no bus activity. All other cycle kinds last three T-states. A read byte is sampled from the shared lines at the mid-point of T3, which is when the read strobe rises. A one-clock done pulse marks the final clock of the cycle. A request is taken only while the controller is idle.

Top module: `mcc_top`

## Requirements
- R1: During reset and while idle: ale_o=0, rd_n_o=1, wr_n_o=1, ad_oe_o=0, done_o=0, busy_o=0 and {io_m_o,s1_o,s0_o}=000.
- R2: A request accepted at a clock edge makes busy_o high from the next clock. It stays high for 8 clocks for an opcode fetch and 6 clocks for every other kind. busy_o then falls, and addr_hi_o shows request address bits 15..8 for the whole cycle.
- R3: ale_o is high only in the first clock (first half) of T1.
- R4: In T1, ad_oe_o=1 and ad_o carries address bits 7..0. For read kinds this holds in both halves of T1.
- R5: For read kinds (fetch, memory read, I/O read), rd_n_o is low from the start of T2 to the mid-point of T3 (3 clocks), and ad_oe_o is 0 from T2 onward.
- R6: For read kinds, rdata_o takes the ad_i value present in the first half of T3. It keeps that value until the next read capture; write cycles leave it unchanged.
- R7: For write kinds (memory write, I/O write), wr_n_o is low from the start of T2 to the mid-point of T3. ad_oe_o=1 and ad_o equals the write byte from the second half of T1 to the end of T3.
- R8: In T4 of an opcode fetch, ale_o=0, rd_n_o=1, wr_n_o=1 and ad_oe_o=0.
- R9: {io_m_o,s1_o,s0_o} is held for the whole cycle: fetch 011, memory read 010, memory write 001, I/O read 110, I/O write 101.
- R10: done_o is high for exactly one clock, the last clock of the cycle.
- R11: req_valid_i while busy_o=1 is ignored; the running cycle is unchanged and no second cycle follows.
- R12: req_type_i codes are 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. Codes 5 to 7 are ignored, and the controller stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the T-state rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| req_type_i | input | 3 | Cycle kind code |
| req_addr_i | input | 16 | Cycle address |
| req_wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | Cycle in progress |
| addr_hi_o | output | 8 | Address bits 15..8 |
| ad_o | output | 8 | Shared address/data lines, outgoing value |
| ad_oe_o | output | 1 | Enable for ad_o onto the shared lines |
| ad_i | input | 8 | Shared lines, incoming value |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | Status: 1 for I/O, 0 for memory |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| rdata_o | output | 8 | Last captured read byte |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
The assertions check, on every clock, rules that need no knowledge of which request is running. The read and write strobes are never low together. The shared lines are never driven while the read strobe is low. The latch strobe lasts one clock and always opens a cycle. Status stays stable during a cycle, and done is followed by idle. Only the bench scenarios show that each strobe edge lands on the right half-state for each cycle kind. They also show that the captured byte is the one present at the T3 mid-point and not a neighbouring one, that the write byte replaces the address at the right time, and that invalid codes and requests made while busy leave the bus untouched.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH  = 3'd0,
    CYC_MEM_RD = 3'd1,
    CYC_MEM_WR = 3'd2,
    CYC_IO_RD  = 3'd3,
    CYC_IO_WR  = 3'd4
  } cyc_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } stat_t;

  function automatic logic cyc_valid(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic cyc_is_read(input cyc_e c);
    return (c == CYC_FETCH) || (c == CYC_MEM_RD) || (c == CYC_IO_RD);
  endfunction

  function automatic logic cyc_is_write(input cyc_e c);
    return (c == CYC_MEM_WR) || (c == CYC_IO_WR);
  endfunction

  function automatic stat_t cyc_status(input cyc_e c);
    stat_t s;
    case (c)
      CYC_FETCH:  s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      CYC_MEM_RD: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      CYC_MEM_WR: s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      CYC_IO_RD:  s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      CYC_IO_WR:  s = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default:    s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mcc_seq.sv
module mcc_seq #(
  parameter int FETCH_T = 4,
  parameter int BASIC_T = 3,
  localparam int PW = $clog2(2 * FETCH_T),
  localparam int TW = PW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          long_i,
  output logic          active_o,
  output logic [TW-1:0] tstate_o,
  output logic          half_o,
  output logic          last_o
);

  localparam logic [PW-1:0] LAST_LONG  = PW'(2 * FETCH_T - 1);
  localparam logic [PW-1:0] LAST_SHORT = PW'(2 * BASIC_T - 1);

  logic          active_q;
  logic [PW-1:0] ph_q;
  logic [PW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      last_q   <= LAST_SHORT;
    end else if (start_i) begin
      active_q <= 1'b1;
      ph_q     <= '0;
      last_q   <= long_i ? LAST_LONG : LAST_SHORT;
    end else if (active_q) begin
      if (ph_q == last_q) begin
        active_q <= 1'b0;
        ph_q     <= '0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign tstate_o = ph_q[PW-1:1];
  assign half_o   = ph_q[0];
  assign last_o   = active_q && (ph_q == last_q);

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !last_o |=> active_q && (ph_q == $past(ph_q) + 1'b1)); // R11

endmodule

// File: rtl/mcc_strobe.sv
module mcc_strobe
  import mcc_pkg::*;
#(
  parameter int TW = 2
) (
  input  logic          active_i,
  input  cyc_e          cyc_i,
  input  logic [TW-1:0] tstate_i,
  input  logic          half_i,
  output logic          ale_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          ad_oe_o,
  output logic          data_sel_o,
  output logic          capture_o,
  output stat_t         stat_o
);

  logic in_t1, in_t2, in_t3, is_rd, is_wr, strobe_win;

  always_comb begin
    in_t1      = active_i && (tstate_i == TW'(0));
    in_t2      = active_i && (tstate_i == TW'(1));
    in_t3      = active_i && (tstate_i == TW'(2));
    is_rd      = cyc_is_read(cyc_i);
    is_wr      = cyc_is_write(cyc_i);
    strobe_win = in_t2 || (in_t3 && !half_i);

    ale_o      = in_t1 && !half_i;
    rd_n_o     = !(is_rd && strobe_win);
    wr_n_o     = !(is_wr && strobe_win);
    ad_oe_o    = in_t1 || (is_wr && (in_t2 || in_t3));
    data_sel_o = is_wr && !(in_t1 && !half_i);
    capture_o  = is_rd && in_t3 && !half_i;
    stat_o     = active_i ? cyc_status(cyc_i) : '0;
  end

endmodule

// File: rtl/mcc_dp.sv
module mcc_dp
  import mcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [2:0]           type_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 capture_i,
  input  logic                 data_sel_i,
  input  logic [DATA_W-1:0]    ad_i,
  output cyc_e                 cyc_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]    ad_o,
  output logic [DATA_W-1:0]    rdata_o
);

  cyc_e              cyc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= CYC_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_i) begin
      cyc_q   <= cyc_e'(type_i);
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= ad_i;
  end

  assign cyc_o     = cyc_q;
  assign addr_hi_o = addr_q[ADDR_W-1:DATA_W];
  assign ad_o      = data_sel_i ? wdata_q : addr_q[DATA_W-1:0];
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/mcc_top.sv
module mcc_top
  import mcc_pkg::*;
#(
  parameter int FETCH_T = 4,
  parameter int BASIC_T = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [2:0]  req_type_i,
  input  logic [15:0] req_addr_i,
  input  logic [7:0]  req_wdata_i,
  output logic        busy_o,
  output logic [7:0]  addr_hi_o,
  output logic [7:0]  ad_o,
  output logic        ad_oe_o,
  input  logic [7:0]  ad_i,
  output logic        ale_o,
  output logic        rd_n_o,
  output logic        wr_n_o,
  output logic        io_m_o,
  output logic        s1_o,
  output logic        s0_o,
  output logic [7:0]  rdata_o,
  output logic        done_o
);

  localparam int PW = $clog2(2 * FETCH_T);
  localparam int TW = PW - 1;

  generate
    if (FETCH_T < 3 || BASIC_T < 3 || BASIC_T > FETCH_T) begin : g_bad_cfg
      initial $error("mcc_top: T-state counts out of range");
    end
  endgenerate

  logic          active, half, last, accept, capture, data_sel;
  logic [TW-1:0] tstate;
  cyc_e          cyc;
  stat_t         stat;

  assign accept = req_valid_i && !active && cyc_valid(req_type_i);

  mcc_seq #(.FETCH_T(FETCH_T), .BASIC_T(BASIC_T)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .long_i   (req_type_i == 3'(CYC_FETCH)),
    .active_o (active),
    .tstate_o (tstate),
    .half_o   (half),
    .last_o   (last)
  );

  mcc_dp #(.ADDR_W(16), .DATA_W(8)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .type_i     (req_type_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .capture_i  (capture),
    .data_sel_i (data_sel),
    .ad_i       (ad_i),
    .cyc_o      (cyc),
    .addr_hi_o  (addr_hi_o),
    .ad_o       (ad_o),
    .rdata_o    (rdata_o)
  );

  mcc_strobe #(.TW(TW)) u_strobe (
    .active_i   (active),
    .cyc_i      (cyc),
    .tstate_i   (tstate),
    .half_i     (half),
    .ale_o      (ale_o),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o),
    .ad_oe_o    (ad_oe_o),
    .data_sel_o (data_sel),
    .capture_o  (capture),
    .stat_o     (stat)
  );

  assign busy_o = active;
  assign done_o = last;
  assign io_m_o = stat.io_m;
  assign s1_o   = stat.s1;
  assign s0_o   = stat.s0;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o)); // R5
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o); // R5
  AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R3
  AST_ALE_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ale_o); // R3
  AST_STATUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable({io_m_o, s1_o, s0_o})); // R9
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ale_o && rd_n_o && wr_n_o && !ad_oe_o && !done_o); // R1

endmodule

// File: tb/mcc_top_tb.sv
module mcc_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_type = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  ad_in = '0;
  logic        busy, ad_oe, ale, rd_n, wr_n, io_m, s1, s0, done;
  logic [7:0]  addr_hi, ad_out, rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] last_rb = 8'h00;

  always #2 clk = ~clk;

  mcc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_type_i(req_type),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy),
    .addr_hi_o(addr_hi), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in),
    .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n), .io_m_o(io_m), .s1_o(s1),
    .s0_o(s0), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " busy"}, 16'(busy), 16'd0);
    chk({tag, " strobes"}, 16'({ale, rd_n, wr_n, ad_oe, done}), 16'b01100);
    chk({tag, " status"}, 16'({io_m, s1, s0}), 16'd0);
  endtask

  task automatic run_cycle(input int ty, input logic [15:0] a, input logic [7:0] wd,
                           input logic [7:0] rb, input bit noise);
    int          n_t = (ty == 0) ? 4 : 3;
    bit          rdk = (ty == 0) || (ty == 1) || (ty == 3);
    bit          wrk = (ty == 2) || (ty == 4);
    logic [2:0]  st;
    case (ty)
      0: st = 3'b011; 1: st = 3'b010; 2: st = 3'b001;
      3: st = 3'b110; default: st = 3'b101;
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_type = 3'(ty); req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = noise;
    if (noise) begin req_type = 3'd0; req_addr = ~a; req_wdata = ~wd; end
    for (int ph = 0; ph < 2 * n_t; ph++) begin
      int t = ph / 2;
      int h = ph % 2;
      bit exp_oe = (t == 0) || (wrk && t <= 2);
      logic [7:0] exp_ad = (t == 0 && (h == 0 || !wrk)) ? a[7:0] : wd;
      bit in_win = (t == 1) || (t == 2 && h == 0);
      ad_in = in_win ? rb : ~rb;
      chk("R2 busy", 16'(busy), 16'd1);
      chk("R2 addr_hi", 16'(addr_hi), 16'(a[15:8]));
      chk("R3 ale", 16'(ale), 16'(t == 0 && h == 0));
      chk("R5 rd_n", 16'(rd_n), 16'(!(rdk && in_win)));
      chk("R7 wr_n", 16'(wr_n), 16'(!(wrk && in_win)));
      if (t == 0) chk("R4 oe", 16'(ad_oe), 16'd1);
      else if (rdk) chk("R5 oe", 16'(ad_oe), 16'd0);
      else chk("R7 oe", 16'(ad_oe), 16'(exp_oe));
      if (exp_oe) chk(t == 0 && h == 0 ? "R4 ad" : (wrk ? "R7 ad" : "R4 ad"),
                      16'(ad_out), 16'(exp_ad));
      if (t == 3) chk("R8 quiet", 16'({ale, rd_n, wr_n, ad_oe}), 16'b0110);
      chk("R9 status", 16'({io_m, s1, s0}), 16'(st));
      chk("R10 done", 16'(done), 16'(ph == 2 * n_t - 1));
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (rdk) last_rb = rb;
    chk(rdk ? "R6 rdata" : "R6 rdata held", 16'(rdata), 16'(last_rb));
    chk_idle(noise ? "R11 after busy req" : "R2 end");
    @(negedge clk);
    chk_idle(noise ? "R11 no second cycle" : "R1 idle");
  endtask

  initial begin : watchdog
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] addrs [4] = '{16'h0000, 16'h4125, 16'hA5C3, 16'hFFFF};
    #1;
    chk_idle("R1 in reset");
    chk("R1 rdata reset", 16'(rdata), 16'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");
    for (int ty = 0; ty < 5; ty++) begin
      for (int i = 0; i < 4; i++) begin
        run_cycle(ty, addrs[i], 8'(8'h3C + ty * 17 + i), 8'(8'h5E ^ (ty * 16 + i * 3)), 1'b0);
      end
    end
    // R11: requests while busy
    run_cycle(1, 16'h2001, 8'h00, 8'h43, 1'b1);
    run_cycle(2, 16'h526A, 8'h9D, 8'h00, 1'b1);
    run_cycle(0, 16'h2000, 8'h00, 8'h06, 1'b1);
    // R12: unused codes ignored
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      req_valid = 1'b1; req_type = 3'(c); req_addr = 16'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      chk_idle("R12 bad code");
      @(negedge clk);
      chk_idle("R12 bad code later");
    end
    // back-to-back with R12 code check on valid code afterwards
    run_cycle(3, 16'h00C0, 8'h00, 8'h5E, 1'b0);
    run_cycle(4, 16'h00C1, 8'h77, 8'h00, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule